// File: doc/BRIEF.md
# GPIO Event Interrupt Controller

This block watches twelve general-purpose input pins and turns selected edges or levels on them into interrupt requests. Every pin first passes through a two-stage synchroniser. A per-pin trigger code then decides what counts as an event on that pin. The choices are a falling edge, a rising edge, both edges, a low level or a high level. An event on an enabled pin latches a sticky pending bit. A single interrupt line is raised while any pending pin is both enabled and unmasked.

Software reaches the block through a plain word-addressed register port. The port has a 3-bit address, 32-bit write data, a write strobe, a read strobe and combinational read data. Trigger codes are packed into two mode words. Pending bits are acknowledged by writing ones. The mask is set through one address and cleared through another, so no read-modify-write is needed.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset the enable bits, pending bits and trigger codes are all zero, every mask bit is one, and `irq` is low.
- R2: Word addresses are: 0 enable (read/write), 1 pending (read only), 2 pending-clear (write only, reads 0), 3 mask (reads mask; writing ones sets mask bits), 4 mask-clear (write only, reads 0), 5 mode word low, 6 mode word high, 7 unused (reads 0). Per-pin words use bits 11:0, and every other bit reads zero.
- R3: The trigger code of pin n (n < 8) is bits 4n+2..4n of the low mode word. The code of pin n (n >= 8) is bits 4(n-8)+2..4(n-8) of the high mode word. Bit 4k+3 of each slot and the unused slots of the high word read zero.
- R4: Code 000 detects a falling edge and code 001 a rising edge. A pin change applied before rising clock edge k shows in the pending word after edge k+2.
- R5: Code 010 sets the pending bit while the synchronised pin is low, and code 011 sets it while the pin is high. When a clear is written while the level is still active, the bit still reads 1 afterwards.
- R6: Code 100 detects both rising and falling edges.
- R7: Codes 101, 110 and 111 never set the pending bit.
- R8: Writing a one to a bit of the pending-clear word clears that pending bit. Zero bits have no effect. If an event and a clear reach the same pin in the same cycle, the bit stays set.
- R9: A pin whose enable bit is zero never sets its pending bit. Events seen while it is disabled are not remembered.
- R10: Writing ones to the mask-clear word clears those mask bits. `irq` is high exactly when some pin has pending, enable set and mask clear. Changing enable does not change pending bits that are already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 12 | Asynchronous pin inputs |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to produce is a pending-clear write that lands in exactly the cycle in which an edge event is being captured. Here the set must win over the clear. The bench counts the two synchroniser stages and the capture register from the moment it changes a pin. It then presents the clear strobe at the one edge where the detector's output is active. It sweeps all eight trigger codes over all twelve pins through a rise and a fall of each pin. At every step it predicts the pending word from the code, so any misplaced mode slot or swapped code shows up in the word.

// File: rtl/gpio_evt_pkg.sv
// Shared constants for the GPIO event interrupt controller.
// Assumes word addressing on a 3-bit register port.
package gpio_evt_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned SLOT_W = 4;
    localparam int unsigned PINS_PER_MODE = 8;

    typedef enum logic [CODE_W-1:0] {
        TRIG_FALL = 3'b000,
        TRIG_RISE = 3'b001,
        TRIG_LOW  = 3'b010,
        TRIG_HIGH = 3'b011,
        TRIG_BOTH = 3'b100
    } trig_e;

    localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT_CLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE_LO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MODE_HI  = 3'd6;
endpackage

// File: rtl/gpio_evt_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is an independent signal (no bus coherency needed).
module gpio_evt_sync #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Shift each pin through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/gpio_evt_detect.sv
// Per-pin event detector: compares each synchronised pin with its value one
// cycle earlier and decodes the pin's 3-bit trigger code into a hit pulse.
// Assumes synchronised inputs; unknown codes produce no hit.
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        level,
    input  logic [NPINS-1:0][CODE_W-1:0] code,
    output logic [NPINS-1:0]        hit
);
    logic [NPINS-1:0] prev_q;

    // Hold last cycle's synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Decode this pin's trigger code against current and previous level.
        always_comb begin
            unique case (code[i])
                TRIG_FALL: hit[i] =  prev_q[i] & ~level[i];
                TRIG_RISE: hit[i] = ~prev_q[i] &  level[i];
                TRIG_LOW:  hit[i] = ~level[i];
                TRIG_HIGH: hit[i] =  level[i];
                TRIG_BOTH: hit[i] =  prev_q[i] ^  level[i];
                default:   hit[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_evt_regs.sv
// Register file: enable, mask, pending bits and packed trigger codes, with
// write-one clear/set ports and a combinational read mux.
// Assumes NPINS <= 16 (two mode words of eight 4-bit slots) and NPINS <= DATA_W.
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS  = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         wr_en,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rdata,
    input  logic [NPINS-1:0]             hit,
    output logic [NPINS-1:0]             enable_q,
    output logic [NPINS-1:0]             mask_q,
    output logic [NPINS-1:0]             status_q,
    output logic [NPINS-1:0][CODE_W-1:0] code_q
);
    localparam int unsigned MODE_WORDS = 2;

    logic [NPINS-1:0]  wbits;
    logic              we_enable, we_clr, we_mset, we_mclr;
    logic [MODE_WORDS-1:0] we_mode;
    logic [NPINS-1:0]  clr_vec;
    logic [DATA_W-1:0] mode_rd [MODE_WORDS];
    logic              unused_wdata_bits;

    assign wbits     = wdata[NPINS-1:0];
    assign we_enable = wr_en && (addr == A_ENABLE);
    assign we_clr    = wr_en && (addr == A_STAT_CLR);
    assign we_mset   = wr_en && (addr == A_MASK);
    assign we_mclr   = wr_en && (addr == A_MASK_CLR);
    assign we_mode[0] = wr_en && (addr == A_MODE_LO);
    assign we_mode[1] = wr_en && (addr == A_MODE_HI);
    assign clr_vec   = we_clr ? wbits : '0;
    assign unused_wdata_bits = ^wdata;

    // Enable register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (we_enable) enable_q <= wbits;
    end

    // Mask register: ones written to one address set, to another clear.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q | (we_mset ? wbits : '0))
                              & ~(we_mclr ? wbits : '0);
    end

    // Pending bits: sticky, cleared by write-one, new events win over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | (hit & enable_q);
    end

    // Trigger codes: each pin loads its slot from its mode word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            for (int i = 0; i < NPINS; i++) begin
                if (we_mode[i / PINS_PER_MODE])
                    code_q[i] <= wdata[(i % PINS_PER_MODE) * SLOT_W +: CODE_W];
            end
        end
    end

    // Pack trigger codes back into the two mode words for readback.
    always_comb begin
        for (int w = 0; w < MODE_WORDS; w++) mode_rd[w] = '0;
        for (int i = 0; i < NPINS; i++)
            mode_rd[i / PINS_PER_MODE][(i % PINS_PER_MODE) * SLOT_W +: CODE_W] = code_q[i];
    end

    // Read mux; returns zero when no read is strobed.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_ENABLE:  rdata[NPINS-1:0] = enable_q;
                A_STATUS:  rdata[NPINS-1:0] = status_q;
                A_MASK:    rdata[NPINS-1:0] = mask_q;
                A_MODE_LO: rdata = mode_rd[0];
                A_MODE_HI: rdata = mode_rd[1];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_evt_irq.sv
// Top of the GPIO event interrupt controller: synchroniser, per-pin event
// detector and register file, with one combined interrupt output.
// Assumes a single clock domain for the register port; pins are asynchronous.
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS  = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq
);
    logic [NPINS-1:0]             pin_sync;
    logic [NPINS-1:0]             hit;
    logic [NPINS-1:0]             enable_q;
    logic [NPINS-1:0]             mask_q;
    logic [NPINS-1:0]             status_q;
    logic [NPINS-1:0][CODE_W-1:0] code_q;

    gpio_evt_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_evt_detect #(.NPINS(NPINS)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pin_sync),
        .code  (code_q),
        .hit   (hit)
    );

    gpio_evt_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr_en    (bus_wr_en),
        .rd_en    (bus_rd_en),
        .rdata    (bus_rdata),
        .hit      (hit),
        .enable_q (enable_q),
        .mask_q   (mask_q),
        .status_q (status_q),
        .code_q   (code_q)
    );

    // Raise the request while any pending, enabled pin is unmasked.
    assign irq = |(status_q & enable_q & ~mask_q);
endmodule

// File: rtl/gpio_evt_chk.sv
// Property checker for gpio_evt_irq, attached by bind. Observes the register
// port, the register state and the detector's hit vector.
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS  = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic                         bus_wr_en,
    input logic                         bus_rd_en,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NPINS-1:0]             enable_q,
    input logic [NPINS-1:0]             mask_q,
    input logic [NPINS-1:0]             status_q,
    input logic [NPINS-1:0]             hit,
    input logic [NPINS-1:0][CODE_W-1:0] code_q
);
    logic past_valid;
    logic unused_chk_bits;

    assign unused_chk_bits = ^bus_wdata;

    // Marks cycles whose previous sample was taken out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_q == '1 && enable_q == '0 && status_q == '0));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr != A_MODE_LO && bus_addr != A_MODE_HI)
        |-> (bus_rdata[DATA_W-1:NPINS] == '0));

    p_clear_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_STAT_CLR)
        |=> ((status_q & $past(bus_wdata[NPINS-1:0] & ~(hit & enable_q))) == '0));

    p_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));

    p_mask_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_MASK_CLR)
        |=> ((mask_q & $past(bus_wdata[NPINS-1:0])) == '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_rsvd
        p_rsvd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (code_q[i] > 3'b100) |-> !hit[i]);
    end
endmodule

bind gpio_evt_irq gpio_evt_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .enable_q  (enable_q),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .hit       (hit),
    .code_q    (code_q)
);

// File: tb/gpio_evt_irq_tb.sv
`timescale 1ns/1ps
module gpio_evt_irq_tb;
    localparam logic [2:0] AD_EN = 3'd0, AD_ST = 3'd1, AD_SC = 3'd2,
                           AD_MK = 3'd3, AD_MC = 3'd4, AD_M0 = 3'd5,
                           AD_M1 = 3'd6, AD_NU = 3'd7;
    localparam logic [31:0] ALL = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic [11:0] pin_in = '0;
    logic        irq;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_evt_irq u_dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .irq (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] mode_word(input int pin, input int code, input bit hi);
        logic [31:0] w = '0;
        if ((pin >= 8) == hi) w[(pin % 8) * 4 +: 3] = code[2:0];
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(AD_EN, d); chk("R1 enable", d, 0);
        rd(AD_ST, d); chk("R1 pending", d, 0);
        rd(AD_MK, d); chk("R1 mask", d, ALL);
        rd(AD_M0, d); chk("R1 mode lo", d, 0);
        rd(AD_M1, d); chk("R1 mode hi", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2/R3: widths and reserved bits
        wr(AD_EN, 32'hFFFF_FFFF); rd(AD_EN, d); chk("R2 enable width", d, ALL);
        wr(AD_M0, 32'hFFFF_FFFF); rd(AD_M0, d); chk("R3 mode lo slots", d, 32'h7777_7777);
        wr(AD_M1, 32'hFFFF_FFFF); rd(AD_M1, d); chk("R3 mode hi slots", d, 32'h0000_7777);
        rd(AD_SC, d); chk("R2 clear word reads zero", d, 0);
        rd(AD_MC, d); chk("R2 mask-clear reads zero", d, 0);
        rd(AD_NU, d); chk("R2 unused address", d, 0);
        rd(AD_ST, d); chk("R7 reserved code idle", d, 0);
        wr(AD_EN, 0); wr(AD_M0, 0); wr(AD_M1, 0);

        // Sweep every pin through every trigger code.
        for (int p = 0; p < 12; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic [31:0] b;
                bit f_fall, f_rise, f_low, f_high, f_both;
                string tag;
                b = 32'd1 << p;
                f_fall = (m == 0); f_rise = (m == 1); f_low = (m == 2);
                f_high = (m == 3); f_both = (m == 4);
                tag = (m < 2) ? "R4" : (m < 4) ? "R5" : (m == 4) ? "R6" : "R7";
                wr(AD_EN, 0);
                wr(AD_M0, mode_word(p, m, 1'b0));
                wr(AD_M1, mode_word(p, m, 1'b1));
                wr(AD_EN, b);
                wr(AD_SC, ALL);
                settle();
                wr(AD_SC, ALL);
                rd(AD_ST, d); chk({"R3 ", tag, " idle low"}, d, f_low ? b : 0);
                @(negedge clk) pin_in[p] = 1'b1;
                settle();
                rd(AD_ST, d); chk({tag, " after rise"}, d, (f_low | f_rise | f_both | f_high) ? b : 0);
                wr(AD_SC, ALL);
                rd(AD_ST, d); chk({tag, " cleared high"}, d, f_high ? b : 0);
                @(negedge clk) pin_in[p] = 1'b0;
                settle();
                rd(AD_ST, d); chk({tag, " after fall"}, d, (f_high | f_fall | f_both | f_low) ? b : 0);
                wr(AD_SC, ALL);
                rd(AD_ST, d); chk({tag, " cleared low"}, d, f_low ? b : 0);
            end
        end
        wr(AD_EN, 0); wr(AD_M0, 0); wr(AD_M1, 0); wr(AD_SC, ALL);

        // R9: disabled pin ignores a rising edge (pin 5, code 001 in slot 5)
        wr(AD_M0, 32'h0010_0000);
        @(negedge clk) pin_in[5] = 1'b1; settle();
        rd(AD_ST, d); chk("R9 disabled no capture", d, 0);
        wr(AD_EN, 32'h20); settle();
        rd(AD_ST, d); chk("R9 no stored event", d, 0);
        @(negedge clk) pin_in[5] = 1'b0; settle();

        // R4 latency: not visible after edge k+1, visible after edge k+2.
        @(negedge clk) pin_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_addr = AD_ST; bus_rd_en = 1'b1; #1 d = bus_rdata; bus_rd_en = 1'b0;
        chk("R4 not yet pending", d, 0);
        @(negedge clk);
        bus_addr = AD_ST; bus_rd_en = 1'b1; #1 d = bus_rdata; bus_rd_en = 1'b0;
        chk("R4 pending at third edge", d, 32'h20);

        // R8: zero bits have no effect
        wr(AD_SC, 0); rd(AD_ST, d); chk("R8 zero write", d, 32'h20);
        wr(AD_SC, ALL & ~32'h20); rd(AD_ST, d); chk("R8 other bits", d, 32'h20);

        // R10: mask and irq
        chk("R10 masked irq", {31'd0, irq}, 0);
        wr(AD_MC, 32'h20); chk("R10 unmasked irq", {31'd0, irq}, 1);
        rd(AD_MK, d); chk("R10 mask value", d, ALL & ~32'h20);
        wr(AD_MK, 32'h20); chk("R10 remasked irq", {31'd0, irq}, 0);
        wr(AD_MC, 32'h20);
        wr(AD_EN, 0); chk("R10 disabled irq", {31'd0, irq}, 0);
        rd(AD_ST, d); chk("R10 pending kept", d, 32'h20);
        wr(AD_EN, 32'h20); chk("R10 re-enabled irq", {31'd0, irq}, 1);
        wr(AD_SC, 32'h20); chk("R8 clear drops irq", {31'd0, irq}, 0);
        rd(AD_ST, d); chk("R8 cleared", d, 0);

        // R8: clear in the capture cycle loses to the event
        @(negedge clk) pin_in[5] = 1'b0; settle();
        @(negedge clk) pin_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = AD_SC; bus_wdata = 32'h20; bus_wr_en = 1'b1;
        @(negedge clk) bus_wr_en = 1'b0;
        rd(AD_ST, d); chk("R8 set wins", d, 32'h20);
        wr(AD_SC, 32'h20); rd(AD_ST, d); chk("R8 later clear", d, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule